// File: doc/BRIEF.md
# Program Address Sequencer with Return Stack

This block produces the fetch address of a small 4-bit processor and keeps its subroutine return addresses in a three-entry on-chip ring. On every cycle with `op_valid` high, it applies one control-flow action to the current address. The actions are: step over a one-byte or two-byte instruction, take a long jump, call, return, take an increment-and-branch loop step, or take an indirect jump inside the page. The decoder supplies the action code and the immediate fields. The register file supplies the index register and the register pair. This block supplies only the next address and the constant that a return places in the accumulator.

In-page branches replace only the low byte of the address. The upper bits come from the address of the byte after the instruction. As a result, a loop branch or indirect jump placed in the last bytes of a 256-byte page lands in the next page. Each return also carries a 4-bit constant, and there is no return that skips this load. When calls nest deeper than three, the oldest saved address is overwritten without notice.

Top module: `prog_seq`

## Requirements
- R1: After synchronous reset, `pc` is 0, `ret_load` is 0, `ret_const` is 0, and all three stack entries are 0, so a return issued straight after reset goes to address 0.
- R2: While `op_valid` is low, `pc` and `ret_const` keep their values and `ret_load` is 0 on the next cycle, whatever `op` says.
- R3: Code 0 advances `pc` by 1 and code 1 advances it by 2, both modulo 4096 (0xFFF + 1 gives 0x000).
- R4: Code 2 (long jump) loads `pc` with `imm_addr`.
- R5: Code 3 (call) saves `pc + 2` on the stack and loads `imm_addr`. Code 4 (return) loads `pc` with the most recently saved address that has not yet been returned to (last in, first out).
- R6: A return (code 4) sets `ret_const` to `imm_const` and drives `ret_load` high for exactly the following cycle. Any other valid code leaves `ret_const` unchanged and `ret_load` low.
- R7: Code 5 (loop) adds 1 to `idx_val` modulo 16. If the sum is non-zero, `pc` becomes {upper 4 bits of `pc + 2`, `imm_page`}. If the sum is zero (`idx_val` = 15), `pc` becomes `pc + 2`.
- R8: A taken loop at page offset 0xFE or 0xFF takes its upper 4 bits from `pc + 2`, so it lands in the next page (at 0x0FE with `imm_page` = 0x34, the result is 0x134).
- R9: Code 6 (indirect jump) sets `pc` to {upper 4 bits of `pc + 1`, `pair_val`}. At offset 0xFF this lands in the next page.
- R10: Calls beyond three levels overwrite the oldest entry. After calls saving A, B, C and D, four returns yield D, C, B and then D again.
- R11: Code 7 is reserved and leaves `pc` unchanged, with `ret_load` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Apply `op` this cycle |
| op | input | 3 | Action code (0 step1, 1 step2, 2 jump, 3 call, 4 return, 5 loop, 6 indirect, 7 reserved) |
| imm_addr | input | 12 | Full target for jump and call |
| imm_page | input | 8 | Low-byte target for loop |
| imm_const | input | 4 | Constant carried by return |
| idx_val | input | 4 | Index register value before increment |
| pair_val | input | 8 | Register pair value for indirect jump |
| pc | output | 12 | Current program address (registered) |
| ret_const | output | 4 | Constant from the last return (registered) |
| ret_load | output | 1 | One-cycle strobe after a return |

## Verification
The bench places loop branches and indirect jumps at offsets 0xFE and 0xFF, where a design that spliced into the current address instead of the following one would stay in the same page. It steps `pc` over 0xFFF, which would land outside the space if the wrap were wrong. It nests four calls and then unwinds them, which exposes a shifting stack that discards the newest entry or a pointer that saturates instead of wrapping. It also returns straight after reset and uses `idx_val` = 15, where a design that branched on the old value instead of the incremented one would branch instead of falling through.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_STEP1 = 3'd0,
    OP_STEP2 = 3'd1,
    OP_JUMP  = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_LOOP  = 3'd5,
    OP_JIND  = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    STK_NONE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_e;
endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack
  import pcs_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_e          cmd,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);

  logic [PTRW-1:0] wr_ptr;
  logic [PTRW-1:0] ptr_up;
  logic [PTRW-1:0] ptr_dn;
  logic [AW-1:0]   ent [DEPTH];

  assign ptr_up = (wr_ptr == LAST) ? '0 : wr_ptr + PTRW'(1);
  assign ptr_dn = (wr_ptr == '0) ? LAST : wr_ptr - PTRW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
    end else if (cmd == STK_PUSH) begin
      wr_ptr <= ptr_up;
    end else if (cmd == STK_POP) begin
      wr_ptr <= ptr_dn;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [AW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (cmd == STK_PUSH && wr_ptr == PTRW'(g)) begin
        slot_q <= push_data;
      end
    end
    assign ent[g] = slot_q;
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ptr_dn == PTRW'(i)) top = ent[i];
    end
  end
endmodule

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
  import pcs_pkg::*;
#(
  parameter int AW = 12,
  parameter int PW = 8,
  parameter int IW = 4
) (
  input  logic [AW-1:0] cur,
  input  op_e           opc,
  input  logic [AW-1:0] far_tgt,
  input  logic [PW-1:0] near_tgt,
  input  logic [IW-1:0] idx,
  input  logic [PW-1:0] pair,
  input  logic [AW-1:0] popped,
  output logic [AW-1:0] nxt,
  output stk_e          scmd,
  output logic [AW-1:0] link,
  output logic          take_const
);
  logic [AW-1:0] after1;
  logic [AW-1:0] after2;
  logic [IW-1:0] idx_inc;
  logic          loop_take;

  assign after1    = cur + AW'(1);
  assign after2    = cur + AW'(2);
  assign idx_inc   = idx + IW'(1);
  assign loop_take = |idx_inc;
  assign link      = after2;

  function automatic logic [AW-1:0] splice(input logic [AW-1:0] base,
                                           input logic [PW-1:0] low);
    return {base[AW-1:PW], low};
  endfunction

  always_comb begin
    nxt        = cur;
    scmd       = STK_NONE;
    take_const = 1'b0;
    unique case (opc)
      OP_STEP1: nxt = after1;
      OP_STEP2: nxt = after2;
      OP_JUMP:  nxt = far_tgt;
      OP_CALL: begin
        nxt  = far_tgt;
        scmd = STK_PUSH;
      end
      OP_RET: begin
        nxt        = popped;
        scmd       = STK_POP;
        take_const = 1'b1;
      end
      OP_LOOP:  nxt = loop_take ? splice(after2, near_tgt) : after2;
      OP_JIND:  nxt = splice(after1, pair);
      OP_RSVD:  nxt = cur;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import pcs_pkg::*;
#(
  parameter int AW    = 12,
  parameter int PW    = 8,
  parameter int CW    = 4,
  parameter int IW    = 4,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    op,
  input  logic [AW-1:0] imm_addr,
  input  logic [PW-1:0] imm_page,
  input  logic [CW-1:0] imm_const,
  input  logic [IW-1:0] idx_val,
  input  logic [PW-1:0] pair_val,
  output logic [AW-1:0] pc,
  output logic [CW-1:0] ret_const,
  output logic          ret_load
);
  logic [AW-1:0] pc_q;
  logic [CW-1:0] rc_q;
  logic          rl_q;
  logic [AW-1:0] nxt_pc;
  logic [AW-1:0] link_addr;
  logic [AW-1:0] stk_top;
  logic          take_const;
  stk_e          raw_cmd;
  stk_e          stk_cmd;

  pcs_next_addr #(.AW(AW), .PW(PW), .IW(IW)) u_next (
    .cur        (pc_q),
    .opc        (op_e'(op)),
    .far_tgt    (imm_addr),
    .near_tgt   (imm_page),
    .idx        (idx_val),
    .pair       (pair_val),
    .popped     (stk_top),
    .nxt        (nxt_pc),
    .scmd       (raw_cmd),
    .link       (link_addr),
    .take_const (take_const)
  );

  assign stk_cmd = op_valid ? raw_cmd : STK_NONE;

  pcs_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .cmd       (stk_cmd),
    .push_data (link_addr),
    .top       (stk_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      rc_q <= '0;
      rl_q <= 1'b0;
    end else begin
      rl_q <= op_valid && take_const;
      if (op_valid) begin
        pc_q <= nxt_pc;
        if (take_const) rc_q <= imm_const;
      end
    end
  end

  assign pc        = pc_q;
  assign ret_const = rc_q;
  assign ret_load  = rl_q;
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int AW = 12,
  parameter int PW = 8,
  parameter int CW = 4,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [2:0]    op,
  input logic [AW-1:0] imm_addr,
  input logic [PW-1:0] imm_page,
  input logic [CW-1:0] imm_const,
  input logic [IW-1:0] idx_val,
  input logic [PW-1:0] pair_val,
  input logic [AW-1:0] pc,
  input logic [CW-1:0] ret_const,
  input logic          ret_load
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(pc) && $stable(ret_const) && !ret_load));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd0) |=> (pc == $past(pc) + ONE));

  assert_step_two_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd1) |=> (pc == $past(pc) + TWO));

  assert_jump_target_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd2) |=> (pc == $past(imm_addr)));

  assert_call_target_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd3) |=> (pc == $past(imm_addr)));

  assert_ret_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd4) |=> (ret_load && ret_const == $past(imm_const)));

  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op != 3'd4) |=> (!ret_load && $stable(ret_const)));

  assert_loop_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd5 && idx_val != '1) |=> (pc[PW-1:0] == $past(imm_page)));

  assert_loop_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd5 && idx_val == '1) |=> (pc == $past(pc) + TWO));

  assert_loop_page_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd5 && idx_val != '1)
      |=> (pc[AW-1:PW] == ($past(pc) + TWO) >> PW));

  assert_indirect_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd6)
      |=> (pc[PW-1:0] == $past(pair_val) && pc[AW-1:PW] == ($past(pc) + ONE) >> PW));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd7) |=> ($stable(pc) && !ret_load));
endmodule

bind prog_seq prog_seq_chk #(.AW(AW), .PW(PW), .CW(CW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op        (op),
  .imm_addr  (imm_addr),
  .imm_page  (imm_page),
  .imm_const (imm_const),
  .idx_val   (idx_val),
  .pair_val  (pair_val),
  .pc        (pc),
  .ret_const (ret_const),
  .ret_load  (ret_load)
);

// File: tb/sim_prog_seq.sv
module sim_prog_seq;
  localparam int AW = 12;
  localparam int PW = 8;
  localparam int CW = 4;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          op_valid;
  logic [2:0]    op;
  logic [AW-1:0] imm_addr;
  logic [PW-1:0] imm_page;
  logic [CW-1:0] imm_const;
  logic [IW-1:0] idx_val;
  logic [PW-1:0] pair_val;
  logic [AW-1:0] pc;
  logic [CW-1:0] ret_const;
  logic          ret_load;

  prog_seq u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .imm_addr(imm_addr),
    .imm_page(imm_page), .imm_const(imm_const), .idx_val(idx_val),
    .pair_val(pair_val), .pc(pc), .ret_const(ret_const), .ret_load(ret_load)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_pc;
  logic [AW-1:0] m_stk [3];
  int            m_sp;
  logic [CW-1:0] m_rc;
  logic          m_rl;

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = '0; m_sp = 0; m_rc = '0; m_rl = 1'b0;
    for (int i = 0; i < 3; i++) m_stk[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; op = '0;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic model_step(logic v, logic [2:0] o, logic [AW-1:0] a,
                            logic [PW-1:0] p, logic [CW-1:0] k,
                            logic [IW-1:0] ix, logic [PW-1:0] pr);
    logic [AW-1:0] t;
    m_rl = 1'b0;
    if (v) begin
      case (o)
        3'd0: m_pc = m_pc + 12'd1;
        3'd1: m_pc = m_pc + 12'd2;
        3'd2: m_pc = a;
        3'd3: begin m_stk[m_sp] = m_pc + 12'd2; m_sp = (m_sp + 1) % 3; m_pc = a; end
        3'd4: begin m_sp = (m_sp + 2) % 3; m_pc = m_stk[m_sp]; m_rc = k; m_rl = 1'b1; end
        3'd5: begin t = m_pc + 12'd2; m_pc = (ix != 4'hF) ? {t[11:8], p} : t; end
        3'd6: begin t = m_pc + 12'd1; m_pc = {t[11:8], pr}; end
        default: ;
      endcase
    end
  endtask

  function automatic string tag_of(logic v, logic [2:0] o);
    if (!v) return "R2";
    case (o)
      3'd0, 3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(logic v, logic [2:0] o, logic [AW-1:0] a,
                       logic [PW-1:0] p, logic [CW-1:0] k,
                       logic [IW-1:0] ix, logic [PW-1:0] pr, string tag);
    @(negedge clk);
    op_valid = v; op = o; imm_addr = a; imm_page = p; imm_const = k;
    idx_val = ix; pair_val = pr;
    model_step(v, o, a, p, k, ix, pr);
    @(posedge clk);
    #1;
    check(tag, "pc", int'(pc), int'(m_pc));
    check(tag, "ret_load", int'(ret_load), int'(m_rl));
    check(tag, "ret_const", int'(ret_const), int'(m_rc));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4004));
    rst = 1'b1; op_valid = 1'b0; op = '0; imm_addr = '0; imm_page = '0;
    imm_const = '0; idx_val = '0; pair_val = '0;
    repeat (3) @(posedge clk);
    do_reset();
    #1;
    check("R1", "pc after reset", int'(pc), 0);
    check("R1", "ret_load after reset", int'(ret_load), 0);
    check("R1", "ret_const after reset", int'(ret_const), 0);
    apply(1, 3'd4, '0, '0, 4'h9, '0, '0, "R1");

    apply(1, 3'd2, 12'h0FE, '0, '0, '0, '0, "R4");
    apply(1, 3'd5, '0, 8'h34, '0, 4'h3, '0, "R8");
    apply(1, 3'd2, 12'h0FF, '0, '0, '0, '0, "R4");
    apply(1, 3'd5, '0, 8'h56, '0, 4'h0, '0, "R8");
    apply(1, 3'd2, 12'h2FE, '0, '0, '0, '0, "R4");
    apply(1, 3'd5, '0, 8'h77, '0, 4'hF, '0, "R7");
    apply(1, 3'd2, 12'h3FF, '0, '0, '0, '0, "R4");
    apply(1, 3'd6, '0, '0, '0, '0, 8'hA5, "R9");
    apply(1, 3'd2, 12'hFFF, '0, '0, '0, '0, "R4");
    apply(1, 3'd0, '0, '0, '0, '0, '0, "R3");
    apply(1, 3'd2, 12'hFFE, '0, '0, '0, '0, "R4");
    apply(1, 3'd1, '0, '0, '0, '0, '0, "R3");

    apply(1, 3'd3, 12'h100, '0, '0, '0, '0, "R10");
    apply(1, 3'd3, 12'h200, '0, '0, '0, '0, "R10");
    apply(1, 3'd3, 12'h300, '0, '0, '0, '0, "R10");
    apply(1, 3'd3, 12'h400, '0, '0, '0, '0, "R10");
    for (int i = 0; i < 4; i++) apply(1, 3'd4, '0, '0, 4'(i + 5), '0, '0, "R10");

    apply(0, 3'd4, 12'h555, '0, 4'hE, '0, '0, "R2");
    apply(0, 3'd2, 12'h777, '0, '0, '0, '0, "R2");
    apply(1, 3'd7, 12'h666, 8'h11, 4'h3, '0, 8'h22, "R11");

    apply(1, 3'd3, 12'h0AB, '0, '0, '0, '0, "R5");
    do_reset();
    apply(1, 3'd4, '0, '0, 4'h2, '0, '0, "R1");

    for (int n = 0; n < 4000; n++) begin
      logic v;
      logic [2:0] o;
      v = ($urandom % 8) != 0;
      o = 3'($urandom % 8);
      apply(v, o, 12'($urandom), 8'($urandom), 4'($urandom),
            4'($urandom), 8'($urandom), tag_of(v, o));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule